// File: doc/BRIEF.md
# Stereo Multi-Format Audio Serial Port

This block moves stereo audio between a parallel sample interface and a single serial data line. Timing comes from two external inputs: a bit clock and a frame (left/right) clock. Both are sampled by the system clock and treated as synchronous inputs. The same datapath handles five framing layouts: left aligned, right aligned, one-bit-delayed (I2S), and two short-sync layouts. Each of the short-sync layouts carries both words back to back after a frame pulse. The word length can be set to 16, 20 or 24 bits.

On the transmit side, a left/right pair is taken through a valid/ready handshake at the start of each frame and shifted out most significant bit first. On the receive side, serial bits are assembled into a pair. The pair is presented with a one-cycle valid strobe once the frame that carried it has ended.

A timing monitor checks every frame-clock phase against the selected word length. It raises a sticky framing-error flag when a phase is too short, and the flag stays set until a clear input is pulsed.

Top module: `asp_top`

## Requirements
- R1: `fmt` code 0 selects left aligned framing. The first bit of a word is driven on the bit-clock falling edge where the frame clock changes, and is sampled on the next rising edge. Frame clock high carries the left word and low carries the right word. `sdout` changes only on bit-clock falling edges.
- R2: `fmt` code 2 selects I2S framing. It is the same as R1 except that the first bit comes one bit-clock period after the frame-clock change.
- R3: `fmt` code 1 selects right aligned framing. The LSB occupies the last bit period of a phase, with the phase length taken as the length of the previous phase at the same frame-clock level. `sdout` is zero, and received words are zero, until that length has been measured since reset.
- R4: `fmt` code 3 and code 4 select short-sync framing. A frame starts at the frame-clock rising edge, and the left word is followed directly by the right word. With code 3 the first bit comes one bit period after the rise; with code 4 it comes in the same bit period as the rise.
- R5: `wlen` code 0 selects 16 bits, code 1 selects 20 bits, and codes 2 and 3 select 24 bits. Samples sit in the low n bits of the buses, and upper bus bits are ignored. Bits are sent MSB first.
- R6: In every bit period that carries no word bit, `sdout` is 0.
- R7: `tx_ready` is high for exactly one clock cycle at the bit-clock falling edge where the frame clock rises, and a pair is taken when `tx_valid` is high in that cycle. A frame with no pair taken transmits all zeros.
- R8: `rx_valid` pulses for one cycle at each frame-clock rise after the first one since reset. It presents the pair sampled on bit-clock rising edges during the preceding frame.
- R9: In codes 0, 1 and 2, a frame-clock phase shorter than n bit periods sets `frame_err`. Any duty cycle with both phases at n or more is accepted.
- R10: In codes 3 and 4, a frame shorter than 2n bit periods, measured between frame-clock rises, sets `frame_err`.
- R11: `frame_err` stays set until `err_clr` is pulsed. A clear takes effect on the next clock.
- R12: After reset, `sdout`, `rx_valid`, `rx_left`, `rx_right` and `frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 3 | Framing layout code |
| wlen | input | 2 | Word length code |
| bclk | input | 1 | Bit clock, sampled by clk |
| lrclk | input | 1 | Frame / channel clock, sampled by clk |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit pair taken this cycle |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |
| err_clr | input | 1 | Clears the framing-error flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The bench builds the block with its default parameters: 24-bit sample buses and an 8-bit bit-period counter. This lets all three word lengths run at full width, and lets phases of up to 255 bit periods be measured. Phase lengths in the bench range from 10 to 48 bit periods. That range covers phases exactly at the n and 2n limits, phases just under those limits, and uneven duty cycles. Sample buses are loaded with bits set above the selected word length, so that truncation is visible at the serial line.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/asp_slot_map.sv
// Maps a bit-period index inside a phase or frame to a word bit position.
module asp_slot_map
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  fmt_e             fmt,
  input  logic [CNT_W-1:0] nbits,
  input  logic [CNT_W-1:0] slot,
  input  logic [CNT_W-1:0] plen,
  input  logic             plen_ok,
  input  logic             level,
  output logic             hit,
  output logic             right,
  output logic [IDX_W-1:0] idx
);
  logic [CNT_W-1:0] pos, lag, two_n, t;

  always_comb begin
    hit   = 1'b0;
    right = ~level;
    pos   = '0;
    two_n = nbits << 1;
    lag   = (fmt == FMT_DSPA) ? CNT_W'(1) : '0;
    t     = slot - lag;
    case (fmt)
      FMT_LJ: if (slot < nbits) begin
        hit = 1'b1;
        pos = nbits - slot - CNT_W'(1);
      end
      FMT_I2S: if (slot != '0 && slot <= nbits) begin
        hit = 1'b1;
        pos = nbits - slot;
      end
      FMT_RJ: if (plen_ok && slot < plen && (plen - slot) <= nbits) begin
        hit = 1'b1;
        pos = plen - slot - CNT_W'(1);
      end
      FMT_DSPA, FMT_DSPB: if (slot >= lag) begin
        if (t < nbits) begin
          hit   = 1'b1;
          right = 1'b0;
          pos   = nbits - t - CNT_W'(1);
        end else if (t < two_n) begin
          hit   = 1'b1;
          right = 1'b1;
          pos   = two_n - t - CNT_W'(1);
        end
      end
      default: ;
    endcase
    idx = pos[IDX_W-1:0];
  end
endmodule

// File: rtl/asp_timing.sv
// Edge detection, bit-period counting, phase measurement, framing check.
module asp_timing
  import asp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic [CNT_W-1:0] nbits,
  input  logic             bclk,
  input  logic             lrclk,
  input  logic             err_clr,
  output logic             fall,
  output logic             rise,
  output logic             frame_start,
  output logic             seen,
  output logic [CNT_W-1:0] slot_next,
  output logic [CNT_W-1:0] slot_cur,
  output logic             level_cur,
  output logic [CNT_W-1:0] len_hi,
  output logic [CNT_W-1:0] len_lo,
  output logic             hi_ok,
  output logic             lo_ok,
  output logic             frame_err
);
  logic             bclk_q, lr_last, lr_last_n, seen_n, err_n;
  logic             hi_ok_n, lo_ok_n, lr_edge, is_dsp, restart;
  logic [CNT_W-1:0] cnt, cnt_n, run_len, len_hi_n, len_lo_n;

  always_comb begin
    fall        = bclk_q & ~bclk;
    rise        = ~bclk_q & bclk;
    lr_edge     = fall && (lrclk != lr_last);
    frame_start = lr_edge && lrclk;
    is_dsp      = (fmt == FMT_DSPA) || (fmt == FMT_DSPB);
    restart     = is_dsp ? frame_start : lr_edge;
    run_len     = (&cnt) ? cnt : cnt + CNT_W'(1);
    slot_next   = restart ? '0 : run_len;
    cnt_n       = fall ? slot_next : cnt;
    lr_last_n   = fall ? lrclk : lr_last;
    seen_n      = seen | frame_start;
    len_hi_n    = len_hi;
    len_lo_n    = len_lo;
    hi_ok_n     = hi_ok;
    lo_ok_n     = lo_ok;
    err_n       = err_clr ? 1'b0 : frame_err;
    if (lr_edge && seen) begin
      if (is_dsp) begin
        if (frame_start && run_len < (nbits << 1)) err_n = 1'b1;
      end else begin
        if (run_len < nbits) err_n = 1'b1;
        if (lr_last) begin
          len_hi_n = run_len;
          hi_ok_n  = 1'b1;
        end else begin
          len_lo_n = run_len;
          lo_ok_n  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b1;
      lr_last   <= 1'b0;
      cnt       <= '0;
      seen      <= 1'b0;
      len_hi    <= '0;
      len_lo    <= '0;
      hi_ok     <= 1'b0;
      lo_ok     <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      bclk_q    <= bclk;
      lr_last   <= lr_last_n;
      cnt       <= cnt_n;
      seen      <= seen_n;
      len_hi    <= len_hi_n;
      len_lo    <= len_lo_n;
      hi_ok     <= hi_ok_n;
      lo_ok     <= lo_ok_n;
      frame_err <= err_n;
    end
  end

  assign slot_cur  = cnt;
  assign level_cur = lr_last;

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err);
  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !lr_edge) |=> !frame_err);
endmodule

// File: rtl/asp_tx.sv
// Transmit word holding and serial output register.
module asp_tx #(
  parameter int SAMPLE_W = 24,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall,
  input  logic                frame_start,
  input  logic                hit,
  input  logic                right,
  input  logic [IDX_W-1:0]    idx,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                sdout
);
  logic [SAMPLE_W-1:0] cur_l, cur_r, cur_l_n, cur_r_n, word;
  logic                sdout_n;

  always_comb begin
    tx_ready = frame_start;
    cur_l_n  = cur_l;
    cur_r_n  = cur_r;
    if (frame_start) begin
      cur_l_n = tx_valid ? tx_left  : '0;
      cur_r_n = tx_valid ? tx_right : '0;
    end
    word    = right ? cur_r_n : cur_l_n;
    sdout_n = sdout;
    if (fall) sdout_n = (hit && 32'(idx) < SAMPLE_W) ? word[idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l <= '0;
      cur_r <= '0;
      sdout <= 1'b0;
    end else begin
      cur_l <= cur_l_n;
      cur_r <= cur_r_n;
      sdout <= sdout_n;
    end
  end

  // R1
  sdout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdout));
  // R7
  empty_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !sdout);
endmodule

// File: rtl/asp_rx.sv
// Receive word assembly and pair presentation.
module asp_rx #(
  parameter int SAMPLE_W = 24,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise,
  input  logic                frame_start,
  input  logic                seen,
  input  logic                hit,
  input  logic                right,
  input  logic [IDX_W-1:0]    idx,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid
);
  logic [SAMPLE_W-1:0] acc_l, acc_r, acc_l_n, acc_r_n, out_l_n, out_r_n;
  logic                valid_n;

  always_comb begin
    acc_l_n = acc_l;
    acc_r_n = acc_r;
    out_l_n = rx_left;
    out_r_n = rx_right;
    valid_n = 1'b0;
    if (frame_start) begin
      out_l_n = seen ? acc_l : rx_left;
      out_r_n = seen ? acc_r : rx_right;
      valid_n = seen;
      acc_l_n = '0;
      acc_r_n = '0;
    end else if (rise && hit && 32'(idx) < SAMPLE_W) begin
      if (right) acc_r_n[idx] = sdin;
      else       acc_l_n[idx] = sdin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_l    <= '0;
      acc_r    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      acc_l    <= acc_l_n;
      acc_r    <= acc_r_n;
      rx_left  <= out_l_n;
      rx_right <= out_r_n;
      rx_valid <= valid_n;
    end
  end

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (rx_valid || ($stable(rx_left) && $stable(rx_right))));
endmodule

// File: rtl/asp_top.sv
module asp_top
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt,
  input  logic [1:0]          wlen,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdin,
  output logic                sdout,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid,
  input  logic                err_clr,
  output logic                frame_err
);
  logic [1:0]       rst_sync;
  logic             rst_int;
  fmt_e             fmt_q;
  logic [CNT_W-1:0] nbits, slot_next, slot_cur, len_hi, len_lo;
  logic             fall, rise, frame_start, seen, level_cur, hi_ok, lo_ok;
  logic             tx_hit, tx_right_sel, rx_hit, rx_right_sel;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  int unsigned      wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  always_comb begin
    fmt_q = fmt_e'(fmt);
    wb    = word_bits(wlen);
    nbits = CNT_W'((wb < SAMPLE_W) ? wb : SAMPLE_W);
  end

  asp_timing #(.CNT_W(CNT_W)) u_timing (
    .clk(clk), .rst_n(rst_int), .fmt(fmt_q), .nbits(nbits),
    .bclk(bclk), .lrclk(lrclk), .err_clr(err_clr),
    .fall(fall), .rise(rise), .frame_start(frame_start), .seen(seen),
    .slot_next(slot_next), .slot_cur(slot_cur), .level_cur(level_cur),
    .len_hi(len_hi), .len_lo(len_lo), .hi_ok(hi_ok), .lo_ok(lo_ok),
    .frame_err(frame_err)
  );

  asp_slot_map #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_tx_map (
    .fmt(fmt_q), .nbits(nbits), .slot(slot_next),
    .plen(lrclk ? len_hi : len_lo), .plen_ok(lrclk ? hi_ok : lo_ok),
    .level(lrclk), .hit(tx_hit), .right(tx_right_sel), .idx(tx_idx)
  );

  asp_slot_map #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_rx_map (
    .fmt(fmt_q), .nbits(nbits), .slot(slot_cur),
    .plen(level_cur ? len_hi : len_lo), .plen_ok(level_cur ? hi_ok : lo_ok),
    .level(level_cur), .hit(rx_hit), .right(rx_right_sel), .idx(rx_idx)
  );

  asp_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk(clk), .rst_n(rst_int), .fall(fall), .frame_start(frame_start),
    .hit(tx_hit), .right(tx_right_sel), .idx(tx_idx),
    .tx_left(tx_left), .tx_right(tx_right), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .sdout(sdout)
  );

  asp_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst_n(rst_int), .rise(rise), .frame_start(frame_start),
    .seen(seen), .hit(rx_hit), .right(rx_right_sel), .idx(rx_idx),
    .sdin(sdin), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );
endmodule

// File: tb/test_asp_top.sv
`timescale 1ns/1ps
module test_asp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  fmt;
  logic [1:0]  wlen;
  logic        bclk, lrclk, sdin, sdout;
  logic [23:0] tx_left, tx_right, rx_left, rx_right;
  logic        tx_valid, tx_ready, rx_valid, err_clr, frame_err;

  int total = 0;
  int fails = 0;

  int fmt_g, n_g, frame_idx, prev_lo, prev_f;
  bit had_fs, exp_err;
  logic [23:0] pl, pr;

  always #10 clk = ~clk;

  asp_top i_asp_top (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen), .bclk(bclk),
    .lrclk(lrclk), .sdin(sdin), .sdout(sdout), .tx_left(tx_left),
    .tx_right(tx_right), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .err_clr(err_clr), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic nd_bit(int f, int s, int n, int plen, bit known, logic [23:0] w);
    int p;
    case (f)
      0: return (s < n) ? w[n-1-s] : 1'b0;
      2: return (s >= 1 && s <= n) ? w[n-s] : 1'b0;
      1: begin
        p = plen - 1 - s;
        return (known && p >= 0 && p < n) ? w[p] : 1'b0;
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic dsp_bit(int s, int n, int d, logic [23:0] wl, logic [23:0] wr);
    int t = s - d;
    if (t < 0) return 1'b0;
    if (t < n) return wl[n-1-t];
    if (t < 2*n) return wr[2*n-1-t];
    return 1'b0;
  endfunction

  task automatic do_slot(input logic lv, input logic din, input logic exp_sd, input bit fs, input string tag);
    bit rv;
    @(negedge clk);
    bclk = 1'b0; lrclk = lv; sdin = din;
    #1;
    chk(tx_ready == fs, "R7 tx_ready", tx_ready, fs);
    @(negedge clk);
    rv = fs && had_fs;
    chk(rx_valid == rv, "R8 rx_valid", rx_valid, rv);
    if (rv) begin
      chk(rx_left == pl, "R8 R5 rx_left", rx_left, pl);
      chk(rx_right == pr, "R8 R5 rx_right", rx_right, pr);
    end
    if (fs) had_fs = 1'b1;
    @(negedge clk);
    chk(sdout == exp_sd, {tag, " sdout"}, sdout, exp_sd);
    chk(frame_err == exp_err, "R9 R10 R11 frame_err", frame_err, exp_err);
    bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset(input int f, input logic [1:0] wc, input int n);
    fmt = 3'(f); wlen = wc; fmt_g = f; n_g = n;
    rst_n = 1'b0; bclk = 1'b1; lrclk = 1'b0; sdin = 1'b0;
    tx_valid = 1'b0; tx_left = '0; tx_right = '0; err_clr = 1'b0;
    had_fs = 1'b0; exp_err = 1'b0; frame_idx = 0; prev_lo = 0; prev_f = 0;
    pl = '0; pr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdout == 1'b0, "R12 sdout", sdout, 0);
    chk(rx_valid == 1'b0, "R12 rx_valid", rx_valid, 0);
    chk(frame_err == 1'b0, "R12 frame_err", frame_err, 0);
    chk(rx_left == '0 && rx_right == '0, "R12 rx words", rx_left, 0);
    for (int i = 0; i < 3; i++) do_slot(1'b0, 1'b0, 1'b0, 1'b0, "R6 idle");
  endtask

  task automatic nd_frame(input int hi, input int lo, input bit v,
                          input logic [23:0] tl, input logic [23:0] tr,
                          input logic [23:0] rl, input logic [23:0] rr, input string tag);
    logic [23:0] wl, wr, mask;
    bit known;
    wl = v ? tl : '0;
    wr = v ? tr : '0;
    mask = 24'((32'd1 << n_g) - 1);
    known = (fmt_g != 1) || (frame_idx > 0);
    tx_left = tl; tx_right = tr; tx_valid = v;
    for (int s = 0; s < hi; s++) begin
      if (s == 0 && had_fs && prev_lo < n_g) exp_err = 1'b1;
      do_slot(1'b1, nd_bit(fmt_g, s, n_g, hi, 1'b1, rl),
              nd_bit(fmt_g, s, n_g, hi, known, wl), s == 0, tag);
    end
    for (int s = 0; s < lo; s++) begin
      if (s == 0 && hi < n_g) exp_err = 1'b1;
      do_slot(1'b0, nd_bit(fmt_g, s, n_g, lo, 1'b1, rr),
              nd_bit(fmt_g, s, n_g, lo, known, wr), 1'b0, tag);
    end
    pl = known ? (rl & mask) : '0;
    pr = known ? (rr & mask) : '0;
    prev_lo = lo;
    frame_idx++;
  endtask

  task automatic dsp_frame(input int fl, input int pw, input bit v,
                           input logic [23:0] tl, input logic [23:0] tr,
                           input logic [23:0] rl, input logic [23:0] rr, input string tag);
    logic [23:0] wl, wr, mask;
    int d;
    d = (fmt_g == 3) ? 1 : 0;
    wl = v ? tl : '0;
    wr = v ? tr : '0;
    mask = 24'((32'd1 << n_g) - 1);
    tx_left = tl; tx_right = tr; tx_valid = v;
    for (int s = 0; s < fl; s++) begin
      if (s == 0 && had_fs && prev_f < 2*n_g) exp_err = 1'b1;
      do_slot(s < pw, dsp_bit(s, n_g, d, rl, rr), dsp_bit(s, n_g, d, wl, wr), s == 0, tag);
    end
    pl = rl & mask;
    pr = rr & mask;
    prev_f = fl;
    frame_idx++;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    exp_err = 1'b0;
    chk(frame_err == 1'b0, "R11 cleared", frame_err, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog R12 actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1 left aligned, 16 bits, upper bus bits ignored (R5), empty frame (R7)
    do_reset(0, 2'd0, 16);
    nd_frame(18, 18, 1'b1, 24'hFA5A3C, 24'h7701C7, 24'h00BEEF, 24'h001234, "R1 R5 R6");
    nd_frame(22, 17, 1'b1, 24'h00813F, 24'hFFFFFF, 24'h008001, 24'h00F00F, "R1 R5 R6");
    nd_frame(18, 18, 1'b0, 24'h00FFFF, 24'h00FFFF, 24'h005555, 24'h00AAAA, "R7 R6");
    nd_frame(18, 18, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R7");
    // R2 I2S, 24 bits
    do_reset(2, 2'd2, 24);
    nd_frame(25, 32, 1'b1, 24'hC3A501, 24'h800001, 24'h123456, 24'hFEDCBA, "R2 R5 R6");
    nd_frame(25, 32, 1'b1, 24'h5A5A5A, 24'hA5A5A5, 24'h800000, 24'h000001, "R2 R5 R6");
    nd_frame(25, 32, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R2 R7");
    // R3 right aligned, 20 bits
    do_reset(1, 2'd1, 20);
    nd_frame(24, 24, 1'b1, 24'hF8C3E1, 24'h0ABCDE, 24'h012345, 24'h0FEDCB, "R3 R6");
    nd_frame(24, 24, 1'b1, 24'hF8C3E1, 24'h0ABCDE, 24'h080001, 24'h07FFFE, "R3 R5 R6");
    nd_frame(24, 24, 1'b1, 24'h0F0F0F, 24'h0C0003, 24'h0, 24'h0, "R3 R6");
    nd_frame(24, 24, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R3 R7");
    // R4 short sync, one bit delay
    do_reset(3, 2'd0, 16);
    dsp_frame(40, 1, 1'b1, 24'h00ACE1, 24'h00BD02, 24'h001357, 24'h002468, "R4 R6");
    dsp_frame(40, 1, 1'b1, 24'hFF8001, 24'h007FFE, 24'h00C0DE, 24'h00F00D, "R4 R5 R6");
    dsp_frame(40, 1, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R4 R7");
    // R4 short sync, no delay, 24 bits, then R10 short frame
    do_reset(4, 2'd3, 24);
    dsp_frame(48, 3, 1'b1, 24'hABCDEF, 24'h102030, 24'h876543, 24'h0F1E2D, "R4 R5 R6");
    dsp_frame(48, 3, 1'b1, 24'h800001, 24'h7FFFFE, 24'h111111, 24'hEEEEEE, "R4 R6");
    dsp_frame(46, 3, 1'b1, 24'h0, 24'h0, 24'h0, 24'h0, "R10");
    dsp_frame(48, 3, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R10 R11");
    chk(frame_err == 1'b1, "R10 short frame flagged", frame_err, 1);
    clear_err();
    dsp_frame(48, 3, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R11");
    // R9 minimum phases with uneven duty accepted, short phase flagged
    do_reset(0, 2'd0, 16);
    nd_frame(16, 20, 1'b1, 24'h00F00F, 24'h000FF0, 24'h00A0A0, 24'h000A0A, "R9 R1");
    nd_frame(16, 16, 1'b1, 24'h00F00F, 24'h000FF0, 24'h00A0A0, 24'h000A0A, "R9 R1");
    chk(frame_err == 1'b0, "R9 minimum accepted", frame_err, 0);
    nd_frame(10, 20, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R9");
    nd_frame(20, 20, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R9 R11");
    chk(frame_err == 1'b1, "R9 short phase flagged", frame_err, 1);
    clear_err();
    nd_frame(20, 20, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0, "R11");
    summary();
    $finish;
  end
endmodule